// File: doc/BRIEF.md
# External Interrupt Flag Controller

This block turns three external pins into interrupt requests for a small processor core. Each pin first passes through a two-stage synchronizer. A per-channel detector then looks for the event that the channel's 2-bit sense code selects: a low level, any change, a falling edge or a rising edge. An edge or change event sets a sticky flag. A low-level channel keeps no flag and requests for as long as its synchronized pin stays low. The pin is only ever read, so a pin that the chip itself drives as an output can raise its own interrupt, which gives software a way to interrupt itself.

Software sees two 8-bit registers on a plain register bus: an enable mask and a flag register. A flag clears when the core acknowledges that channel or when software writes a one to its bit. The core supplies a global interrupt enable. A channel's request reaches the core only when that global enable and the channel's own mask bit are both set. Vector fetch, priority against other interrupt sources and storage of the global enable are outside this block.

Top module: `ext_irq_ctrl`

## Requirements
- R1: During reset both registers read 0x00. The synchronizer stages reset to logic high, so a pin held high through reset causes no event when reset is released.
- R2: `reg_addr_i` = 0 selects the mask register and 1 selects the flag register. Bit i (i = 0..2) belongs to channel i. A write to the mask stores all 8 bits. Flag bits 7..3 store whatever is written and have no effect. `reg_rdata_o` shows the addressed register combinationally.
- R3: Sense code per channel in `sense_i[2i+1:2i]`: 00 = low level, 01 = any change, 10 = falling edge, 11 = rising edge. When the selected event occurs, flag bit i reads 1 after the third rising clock edge that follows the pin change. An event that is not selected leaves the flag at 0.
- R4: Writing the flag register clears every channel bit written as 1 and leaves every channel bit written as 0 unchanged.
- R5: A one-cycle pulse on `ack_i[i]` clears flag bit i at that clock edge.
- R6: If a detected event and a clear (from software or from an acknowledge) reach the same channel on the same edge, the flag ends up set.
- R7: While channel i has sense code 00, flag bit i reads 0 and stays cleared, from the same cycle in which the code is applied.
- R8: In low-level mode, `irq_o[i]` is 1 exactly while the synchronized pin is low and the enables allow it. The request follows the pin two edges later and is not latched.
- R9: In an edge mode, `irq_o[i]` equals flag bit i AND mask bit i AND `gie_i`. A request of either kind is 0 whenever `gie_i` or mask bit i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 3 | Raw external pin levels, asynchronous |
| sense_i | input | 6 | Per-channel 2-bit sense codes |
| gie_i | input | 1 | Global interrupt enable from the core |
| ack_i | input | 3 | Per-channel interrupt acknowledge pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 mask, 1 flag |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 3 | Per-channel interrupt request |

## Verification
The assertions assume that `rst_n` is asserted before the first clock edge and that pins are held high during reset. They make no assumption about pin timing, because the synchronizer output they observe is already clock-aligned. The bench changes pins and sense codes only at falling clock edges. It switches a channel into low-level mode before moving that channel's pin to a new start value, so that no unintended edge is flagged. This keeps every expected flag and request value a fixed number of edges after each stimulus.

// File: rtl/eic_pkg.sv
package eic_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  localparam logic REG_MASK = 1'b0;
  localparam logic REG_FLAG = 1'b1;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int   W       = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, q_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      q_q    <= {W{RST_VAL}};
      prev_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d_i;
      q_q    <= meta_q;
      prev_q <= q_q;
    end
  end

  assign q_o    = q_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/eic_detect.sv
module eic_detect
  import eic_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [2*NCH-1:0] sense_i,
  input  logic [NCH-1:0]   cur_i,
  input  logic [NCH-1:0]   prev_i,
  output logic [NCH-1:0]   hit_o,
  output logic [NCH-1:0]   lvl_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    sense_e mode;
    logic   rise, fall;
    assign mode = sense_e'(sense_i[2*i +: 2]);
    assign rise = cur_i[i] & ~prev_i[i];
    assign fall = ~cur_i[i] & prev_i[i];

    always_comb begin
      hit_o[i] = 1'b0;
      lvl_o[i] = 1'b0;
      unique case (mode)
        SNS_LOW:  lvl_o[i] = 1'b1;
        SNS_ANY:  hit_o[i] = rise | fall;
        SNS_FALL: hit_o[i] = fall;
        SNS_RISE: hit_o[i] = rise;
        default:  hit_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_i,
  input  logic           addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [NCH-1:0] hit_i,
  input  logic [NCH-1:0] lvl_i,
  input  logic [NCH-1:0] ack_i,
  output logic [DW-1:0]  mask_o,
  output logic [DW-1:0]  flag_o,
  output logic [DW-1:0]  rdata_o
);
  localparam int SPARE = DW - NCH;

  logic             wr_mask, wr_flag;
  logic [DW-1:0]    mask_q;
  logic [NCH-1:0]   chan_q, chan_nxt, chan_vis;
  logic [SPARE-1:0] spare_q;

  assign wr_mask = we_i & (addr_i == REG_MASK);
  assign wr_flag = we_i & (addr_i == REG_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       spare_q <= '0;
    else if (wr_flag) spare_q <= wdata_i[DW-1:NCH];
  end

  // Priority per channel: level mode forces clear, then set, then clear.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (lvl_i[i])                               chan_nxt[i] = 1'b0;
      else if (hit_i[i])                          chan_nxt[i] = 1'b1;
      else if (ack_i[i] | (wr_flag & wdata_i[i])) chan_nxt[i] = 1'b0;
      else                                        chan_nxt[i] = chan_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_q <= '0;
    else        chan_q <= chan_nxt;
  end

  // Mask the stored bit so a newly selected level mode reads zero at once.
  assign chan_vis = chan_q & ~lvl_i;
  assign mask_o   = mask_q;
  assign flag_o   = {spare_q, chan_vis};
  assign rdata_o  = (addr_i == REG_FLAG) ? flag_o : mask_q;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_i,
  input  logic [2*NCH-1:0] sense_i,
  input  logic           gie_i,
  input  logic [NCH-1:0] ack_i,
  input  logic           reg_we_i,
  input  logic           reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0] pin_s, pin_p, hit, lvl;
  logic [DW-1:0]  mask_q, flag_q;

  eic_sync #(.W(NCH), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s), .prev_o(pin_p)
  );

  eic_detect #(.NCH(NCH)) u_det (
    .sense_i(sense_i), .cur_i(pin_s), .prev_i(pin_p), .hit_o(hit), .lvl_o(lvl)
  );

  eic_regs #(.NCH(NCH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .hit_i(hit), .lvl_i(lvl), .ack_i(ack_i),
    .mask_o(mask_q), .flag_o(flag_q), .rdata_o(reg_rdata_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_req
    logic src;
    assign src      = lvl[i] ? ~pin_s[i] : flag_q[i];
    assign irq_o[i] = gie_i & mask_q[i] & src;
  end
endmodule

// File: rtl/eic_chk.sv
module eic_chk #(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*NCH-1:0] sense_i,
  input logic           gie_i,
  input logic [NCH-1:0] ack_i,
  input logic           we_i,
  input logic           addr_i,
  input logic [DW-1:0]  wdata_i,
  input logic [DW-1:0]  mask_q,
  input logic [DW-1:0]  flag_q,
  input logic [NCH-1:0] hit,
  input logic [NCH-1:0] pin_s,
  input logic [NCH-1:0] irq_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (mask_q == '0 && flag_q == '0)
        else $error("R1 registers not zero in reset");
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic is_lvl, w1c;
    assign is_lvl = (sense_i[2*i +: 2] == 2'b00);
    assign w1c    = we_i & addr_i & wdata_i[i];

    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> (flag_q[i] || sense_i[2*i +: 2] == 2'b00))
      else $error("R3 flag not set");

    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c && !hit[i]) |=> !flag_q[i])
      else $error("R4 write-one did not clear");

    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[i] && !hit[i]) |=> !flag_q[i])
      else $error("R5 ack did not clear");

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && (ack_i[i] || w1c)) |=> (flag_q[i] || sense_i[2*i +: 2] == 2'b00))
      else $error("R6 clear beat set");

    a_r7_level_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
      is_lvl |-> !flag_q[i])
      else $error("R7 flag set in level mode");

    a_r8_level_request: assert property (@(posedge clk) disable iff (!rst_n)
      (is_lvl && gie_i && mask_q[i]) |-> (irq_o[i] == !pin_s[i]))
      else $error("R8 level request wrong");

    a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[i] |-> (gie_i && mask_q[i]))
      else $error("R9 request without enables");
  end
endmodule

bind ext_irq_ctrl eic_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sense_i(sense_i), .gie_i(gie_i), .ack_i(ack_i),
  .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
  .mask_q(mask_q), .flag_q(flag_q), .hit(hit), .pin_s(pin_s), .irq_o(irq_o)
);

// File: tb/sim_ext_irq_ctrl.sv
`timescale 1ns/1ps
module sim_ext_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [2:0] pin = 3'b111;
  logic [5:0] sense = '0;
  logic       gie = 1'b0;
  logic [2:0] ack = '0;
  logic       we = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ext_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .sense_i(sense), .gie_i(gie),
    .ack_i(ack), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {sense[1:0], pin start, pin end, expected flag}
  localparam logic [4:0] VEC [8] = '{
    5'b11_01_1, 5'b11_10_0, 5'b10_10_1, 5'b10_01_0,
    5'b01_01_1, 5'b01_10_1, 5'b00_10_0, 5'b01_11_0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    #2 rst_n = 1'b0;
    cyc(2);
    rd(1'b0, d); check("R1 mask in reset", d, 8'h00);
    rd(1'b1, d); check("R1 flag in reset", d, 8'h00);
    check("R1 irq in reset", irq, 3'b000);
    rst_n = 1'b1;
    cyc(4);
    rd(1'b1, d); check("R1 no event after reset release", d, 8'h00);

    // R2 register storage
    wr(1'b0, 8'hA5);
    rd(1'b0, d); check("R2 mask readback", d, 8'hA5);
    wr(1'b1, 8'hF8);
    rd(1'b1, d); check("R2 flag spare bits", d, 8'hF8);
    wr(1'b1, 8'h00);
    rd(1'b1, d); check("R2 flag spare cleared", d, 8'h00);

    // Table walk on channel 0 (R3, R7, R8, R9)
    wr(1'b0, 8'h07);
    gie = 1'b1;
    for (int v = 0; v < 8; v++) begin
      logic [1:0] vs;
      logic p0, p1, ef, ei;
      {vs, p0, p1, ef} = VEC[v];
      ei = (vs == 2'b00) ? ~p1 : ef;
      sense[1:0] = 2'b00;
      pin[0] = p0;
      cyc(4);
      sense[1:0] = vs;
      cyc(1);
      pin[0] = p1;
      cyc(4);
      rd(1'b1, d);
      check($sformatf("R3 R7 vector %0d flag", v), d[0], ef);
      check($sformatf("R8 R9 vector %0d irq", v), irq[0], ei);
    end
    sense[1:0] = 2'b00;
    pin[0] = 1'b1;
    cyc(4);

    // R3 event visible after the third edge
    sense[3:2] = 2'b10;
    cyc(1);
    pin[1] = 1'b0;
    cyc(2);
    rd(1'b1, d); check("R3 flag not yet after two edges", d[1], 1'b0);
    cyc(1);
    rd(1'b1, d); check("R3 flag after three edges", d[1], 1'b1);

    // R4 write-one-to-clear
    wr(1'b1, 8'h01);
    rd(1'b1, d); check("R4 zero bit leaves flag", d[1], 1'b1);
    // R9 gating
    gie = 1'b0; #1;
    check("R9 gie low blocks", irq[1], 1'b0);
    gie = 1'b1; wr(1'b0, 8'h05);
    check("R9 mask low blocks", irq[1], 1'b0);
    wr(1'b0, 8'h07);
    check("R9 both enables", irq[1], 1'b1);
    wr(1'b1, 8'h02);
    rd(1'b1, d); check("R4 one bit clears flag", d[1], 1'b0);

    // R6 set wins over clear and ack in the same cycle
    sense[3:2] = 2'b11;
    cyc(1);
    pin[1] = 1'b1;
    cyc(2);
    we = 1'b1; addr = 1'b1; wdata = 8'h02; ack[1] = 1'b1;
    cyc(1);
    we = 1'b0; ack[1] = 1'b0;
    rd(1'b1, d); check("R6 set wins", d[1], 1'b1);
    cyc(1);
    rd(1'b1, d); check("R6 flag holds", d[1], 1'b1);

    // R5 acknowledge clears
    ack[1] = 1'b1;
    cyc(1);
    ack[1] = 1'b0;
    rd(1'b1, d); check("R5 ack clears", d[1], 1'b0);

    // R7 switching to level mode hides a set flag at once
    sense[5:4] = 2'b10;
    cyc(1);
    pin[2] = 1'b0;
    cyc(4);
    rd(1'b1, d); check("R7 setup flag set", d[2], 1'b1);
    sense[5:4] = 2'b00; #1;
    rd(1'b1, d); check("R7 level hides flag", d[2], 1'b0);
    check("R8 level low requests", irq[2], 1'b1);

    // R8 level request follows pin two edges later, not latched
    pin[2] = 1'b1;
    cyc(1);
    check("R8 still low after one edge", irq[2], 1'b1);
    cyc(1);
    check("R8 released after two edges", irq[2], 1'b0);
    pin[2] = 1'b0;
    cyc(2);
    check("R8 reasserts", irq[2], 1'b1);
    rd(1'b1, d); check("R7 flag stays zero", d[2], 1'b0);

    finish_run();
  end
endmodule